// File: doc/BRIEF.md
# Soft-Start and Overcurrent Hiccup Sequencer

This block is the digital sequencer for a voltage-mode step-down converter. It runs on a fast system clock and receives a one-cycle pulse that marks the start of each switching period. It produces a binary reference code for the DAC that feeds the error amplifier's reference input. At start-up the code climbs from zero to full scale in equal steps, one step every `STEP_TICKS` switching periods. Once it reaches full scale, the block regulates with the code held at all ones. It also passes the raw PWM demand through to the power switch gate, or blocks it.

Overcurrent handling depends on the phase. An overcurrent flag only counts after a blanking window of `BLANK_CYCLES` fast clocks, measured from each rising edge of the gate. During the ramp, a counted overcurrent ends the present pulse and blocks the gate for the rest of that switching period, and the ramp carries on. During regulation, a counted overcurrent blocks the gate at once. At the next period boundary the sequencer then drops into a hiccup state with a zero reference. It stays there for as many periods as a full ramp takes, and then starts a fresh ramp. If the supply-good/enable input drops, the block returns to idle.

Named states: IDLE (code 0), RAMP (code 1), RUN (code 2), HICCUP (code 3). Named transitions:
- START: IDLE to RAMP on a tick with supply good.
- RAMP_DONE: RAMP to RUN on the tick that completes the last step.
- TRIP: RUN to HICCUP on a tick that closes a period in which an overcurrent was counted.
- RETRY: HICCUP to RAMP after the hold count.
- DROP: any state to IDLE when supply good is low.

Top module: `ssq_sequencer`

## Requirements
- R1: While reset is asserted, and right after it, `seq_state` is 0 (IDLE), `ref_code` is 0, and `gate_en` and `skip_flag` are 0.
- R2: In IDLE with `pwr_ok` high, the first `sw_tick` moves the block to RAMP (code 1), and `ref_code` starts at 0.
- R3: In RAMP, `ref_code` rises by exactly 1 on every `STEP_TICKS`-th tick. On tick number 2^REF_BITS × STEP_TICKS after entry, the block moves to RUN (code 2) with `ref_code` all ones. `ref_code` stays all ones throughout RUN.
- R4: `seq_state` changes only on a clock edge where `sw_tick` is high, except for the DROP transition.
- R5: `gate_en` follows `pwm_req` only in RAMP or RUN, with `pwr_ok` high and `skip_flag` low. In RUN, a `pwm_req` held high keeps `gate_en` high across period boundaries (100 % duty).
- R6: `ocp_flag` is ignored until `gate_en` has been high for `BLANK_CYCLES` clock edges since its last rising edge.
- R7: A counted overcurrent sets `skip_flag` and forces `gate_en` low from the next clock edge until the next `sw_tick` edge, which clears `skip_flag`.
- R8: In RAMP, a counted overcurrent does not change the state or the ramp timing of `ref_code`.
- R9: In RUN, a counted overcurrent makes the next tick move the block to HICCUP (code 3), with `ref_code` 0 and the gate held off.
- R10: HICCUP lasts 2^REF_BITS × STEP_TICKS ticks. The last of these ticks moves the block to RAMP with `ref_code` 0. `ocp_flag` has no effect during HICCUP.
- R11: `pwr_ok` low forces `gate_en` low at once and, at the next clock edge, sets IDLE with `ref_code` 0. A new ramp from 0 starts on the first tick after `pwr_ok` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| sw_tick | input | 1 | One-cycle pulse marking the start of a switching period |
| pwr_ok | input | 1 | Enable and input-voltage-good, combined |
| pwm_req | input | 1 | Raw on-demand from the PWM comparator |
| ocp_flag | input | 1 | Overcurrent comparator output |
| ref_code | output | REF_BITS | Reference code for the reference DAC |
| gate_en | output | 1 | Enable for the high-side switch driver |
| skip_flag | output | 1 | High while the rest of the period is blocked |
| seq_state | output | 2 | Sequencer state code: 0 IDLE, 1 RAMP, 2 RUN, 3 HICCUP |

## Verification
The hardest condition to reach is a counted overcurrent during RUN followed by the full hiccup hold. It needs a complete ramp first, and then the overcurrent pulse must land after the blanking window inside a single period. The bench therefore uses a small configuration (4-bit code, 4 ticks per step, 8-cycle blanking). It drives every period from one task that places the PWM rising edge and the overcurrent pulse at chosen cycle offsets. The expected outcome of each period follows from the arithmetic difference between those two offsets. Over the ramp, the overcurrent placement rotates between one cycle before the window closes, exactly where it closes, none, and continuous on-time, so every step sees each case.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_RAMP   = 2'd1,
        SQ_RUN    = 2'd2,
        SQ_HICCUP = 2'd3
    } sq_state_e;
endpackage

// File: rtl/ssq_tick_count.sv
// Counts advance pulses modulo LIMIT; 'last' marks the final count.
module ssq_tick_count #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssq_blank_timer.sv
// Measures on-time since the gate's rising edge; saturates when armed.
module ssq_blank_timer #(
    parameter int BLANK_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    output logic armed
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);

    logic [BW-1:0] cnt_q;

    assign armed = (cnt_q == BW'(BLANK_CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!gate_on) begin
            cnt_q <= '0;
        end else if (!armed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssq_period_guard.sv
// Latches a qualified overcurrent until the next period boundary.
module ssq_period_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_tick,
    input  logic gate_on,
    input  logic armed,
    input  logic ocp_flag,
    output logic kill
);
    logic hit;

    assign hit = gate_on & armed & ocp_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kill <= 1'b0;
        end else if (sw_tick) begin
            kill <= 1'b0;
        end else if (hit) begin
            kill <= 1'b1;
        end
    end
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer
    import ssq_pkg::*;
#(
    parameter int REF_BITS     = 6,
    parameter int STEP_TICKS   = 32,
    parameter int BLANK_CYCLES = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_tick,
    input  logic                pwr_ok,
    input  logic                pwm_req,
    input  logic                ocp_flag,
    output logic [REF_BITS-1:0] ref_code,
    output logic                gate_en,
    output logic                skip_flag,
    output logic [1:0]          seq_state
);
    localparam int                HOLD_TICKS = (1 << REF_BITS) * STEP_TICKS;
    localparam logic [REF_BITS-1:0] REF_MAX  = '1;

    sq_state_e           state_q, state_d;
    logic [REF_BITS-1:0] ref_q;
    logic                step_last, hold_last, ramp_last;
    logic                armed, kill, gate_on;

    // Step timer for the staircase
    ssq_tick_count #(.LIMIT(STEP_TICKS)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SQ_RAMP),
        .adv   (sw_tick),
        .last  (step_last)
    );

    // Zero-reference hold timer
    ssq_tick_count #(.LIMIT(HOLD_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SQ_HICCUP),
        .adv   (sw_tick),
        .last  (hold_last)
    );

    ssq_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_on (gate_on),
        .armed   (armed)
    );

    ssq_period_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_tick  (sw_tick),
        .gate_on  (gate_on),
        .armed    (armed),
        .ocp_flag (ocp_flag),
        .kill     (kill)
    );

    assign ramp_last = step_last && (ref_q == REF_MAX);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!pwr_ok) begin
            state_d = SQ_IDLE;                       // DROP
        end else if (sw_tick) begin
            unique case (state_q)
                SQ_IDLE:   state_d = SQ_RAMP;        // START
                SQ_RAMP:   if (ramp_last) state_d = SQ_RUN;    // RAMP_DONE
                SQ_RUN:    if (kill)      state_d = SQ_HICCUP; // TRIP
                SQ_HICCUP: if (hold_last) state_d = SQ_RAMP;   // RETRY
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: reference code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else begin
            unique case (state_d)
                SQ_IDLE, SQ_HICCUP: ref_q <= '0;
                SQ_RUN:             ref_q <= REF_MAX;
                SQ_RAMP: begin
                    if (state_q != SQ_RAMP) begin
                        ref_q <= '0;
                    end else if (sw_tick && step_last && (ref_q != REF_MAX)) begin
                        ref_q <= ref_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign gate_on   = pwm_req && pwr_ok && !kill &&
                       ((state_q == SQ_RAMP) || (state_q == SQ_RUN));
    assign gate_en   = gate_on;
    assign skip_flag = kill;
    assign ref_code  = ref_q;
    assign seq_state = state_q;
endmodule

// File: rtl/ssq_sequencer_chk.sv
module ssq_sequencer_chk #(
    parameter int REF_BITS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sw_tick,
    input logic                pwr_ok,
    input logic [REF_BITS-1:0] ref_code,
    input logic                gate_en,
    input logic                skip_flag,
    input logic [1:0]          seq_state
);
    assert_idle_on_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (seq_state == 2'd0));

    assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state != $past(seq_state)) && $past(pwr_ok)) |-> $past(sw_tick));

    assert_gate_states_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> ((seq_state == 2'd1) || (seq_state == 2'd2)));

    assert_skip_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        skip_flag |-> !gate_en);

    assert_skip_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_tick |=> !skip_flag);

    assert_zero_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == 2'd0) || (seq_state == 2'd3)) |-> (ref_code == '0));

    assert_full_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2) |-> (ref_code == '1));

    assert_ramp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == 2'd1) && ($past(seq_state) == 2'd1)) |->
        ((ref_code == $past(ref_code)) ||
         (ref_code == REF_BITS'($past(ref_code) + 1'b1))));
endmodule

bind ssq_sequencer ssq_sequencer_chk #(.REF_BITS(REF_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_tick   (sw_tick),
    .pwr_ok    (pwr_ok),
    .ref_code  (ref_code),
    .gate_en   (gate_en),
    .skip_flag (skip_flag),
    .seq_state (seq_state)
);

// File: tb/tb_ssq_sequencer.sv
`timescale 1ns/1ps
module tb_ssq_sequencer;
    localparam int RB    = 4;
    localparam int STEP  = 4;
    localparam int BLANK = 8;
    localparam int P     = 40;
    localparam int RAMPN = (1 << RB) * STEP;
    localparam int MAXC  = (1 << RB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_tick = 1'b0, pwr_ok = 1'b0, pwm_req = 1'b0, ocp_flag = 1'b0;
    logic [RB-1:0] ref_code;
    logic gate_en, skip_flag;
    logic [1:0] seq_state;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    ssq_sequencer #(.REF_BITS(RB), .STEP_TICKS(STEP), .BLANK_CYCLES(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .pwr_ok(pwr_ok),
        .pwm_req(pwm_req), .ocp_flag(ocp_flag), .ref_code(ref_code),
        .gate_en(gate_en), .skip_flag(skip_flag), .seq_state(seq_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One switching period. allowed: state after this tick permits gating.
    // exp0 >= 0: expected gate in the tick cycle itself.
    task automatic period(input int rise, input int ocp_at, input bit allowed, input int exp0);
        bit qual;
        int st1;
        qual = allowed && pwr_ok && (ocp_at >= rise) && ((ocp_at - rise) >= BLANK);
        st1 = 0;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            sw_tick  = (c == 0);
            pwm_req  = (c >= rise);
            ocp_flag = (c == ocp_at);
            #1;
            if (c == 0 && exp0 >= 0) chk("R5 gate held through tick", gate_en, exp0);
            if (c == 1) st1 = seq_state;
            if (c == P - 1) begin
                chk("R6/R7 gate at period end", gate_en, (allowed && pwr_ok && !qual) ? 1 : 0);
                chk("R6/R7/R10 skip at period end", skip_flag, qual ? 1 : 0);
                chk("R4 state steady inside period", seq_state, st1);
            end
        end
        @(negedge clk);
        sw_tick = 1'b0;
        ocp_flag = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 state in reset", seq_state, 0);
        chk("R1 ref in reset", ref_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", seq_state, 0);
        chk("R1 ref after reset", ref_code, 0);
        chk("R1 gate after reset", gate_en, 0);
        chk("R1 skip after reset", skip_flag, 0);

        pwr_ok = 1'b1;
        period(1, -1, 1'b1, -1);
        chk("R2 start state", seq_state, 1);
        chk("R2 start ref", ref_code, 0);

        // Ramp sweep with rotating overcurrent placements
        for (int j = 1; j <= RAMPN; j++) begin
            case (j % 4)
                1: period(2, 2 + BLANK - 1, 1'b1, -1);   // R6 inside blanking
                2: period(2, 2 + BLANK, 1'b1, -1);       // R8 counted, ramp continues
                3: period(3, -1, 1'b1, -1);
                default: period(0, -1, 1'b1, 1);
            endcase
            chk("R3/R8 ramp state", seq_state, (j == RAMPN) ? 2 : 1);
            chk("R3/R8 ramp ref", ref_code, (j < RAMPN) ? (j / STEP) : MAXC);
        end

        // RUN: continuous on-time, then trip
        period(0, -1, 1'b1, 1);
        chk("R5 run state", seq_state, 2);
        chk("R3 run ref", ref_code, MAXC);
        period(2, 2 + BLANK + 3, 1'b1, -1);
        chk("R9 state before boundary", seq_state, 2);
        period(2, -1, 1'b0, -1);
        chk("R9 hiccup state", seq_state, 3);
        chk("R9 hiccup ref", ref_code, 0);

        for (int h = 1; h <= RAMPN; h++) begin
            period(2, (h < RAMPN) ? (2 + BLANK + 1) : -1, (h == RAMPN), -1);
            chk("R10 hold state", seq_state, (h < RAMPN) ? 3 : 1);
            chk("R10 hold ref", ref_code, 0);
        end

        for (int j = 1; j <= 5; j++) period(3, -1, 1'b1, -1);
        chk("R10 restart ramp ref", ref_code, 1);

        // Supply drop mid-period
        @(negedge clk);
        pwm_req = 1'b1;
        #1;
        chk("R11 gate before drop", gate_en, 1);
        pwr_ok = 1'b0;
        #1;
        chk("R11 gate drops at once", gate_en, 0);
        @(negedge clk);
        chk("R11 idle next edge", seq_state, 0);
        chk("R11 ref zero", ref_code, 0);
        for (int j = 0; j < 2; j++) begin
            period(2, -1, 1'b0, -1);
            chk("R11 stays idle", seq_state, 0);
        end
        pwr_ok = 1'b1;
        period(2, -1, 1'b1, -1);
        chk("R11/R2 restart state", seq_state, 1);
        chk("R11/R2 restart ref", ref_code, 0);
        for (int j = 1; j <= STEP; j++) period(2, -1, 1'b1, -1);
        chk("R3 first step after restart", ref_code, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule